// File: doc/BRIEF.md
# Octal Double-Buffered Channel Register Bank

This block keeps the digital codes for eight output channels. Each channel owns two 12-bit registers. A staging register takes new codes from the command path. A live register holds the code that the channel presents. A decoded command strobe can do four things: write a staging register, write both registers of one channel, copy staging into live for any group of channels chosen by a bitmask in one cycle, or program and apply a per-channel power-down state.

Three level inputs shape how codes move and what is shown:

- **`dac_hold`** selects between latched and transparent live registers. While it is high the live registers are latched. While it is low they follow the staging registers.
- **`toggle_sel`** picks which of the two registers each channel shows on its output.
- **`force_clr`, `force_mid`, `force_set`** load a fixed code into every register of every channel, whatever the command path is doing.

Top module: `octal_dac_regbank`

## Requirements
- R1: While `rst` is high at a clock edge, all registers clear. After the edge that follows, every channel code reads 0x000 and every power-down state reads 00. Power-down state 00 means the channel is active.
- R2: The op code on `cmd_op` selects the command, and a command takes effect when `cmd_valid` is high at a clock edge.
  - Op 1 writes `cmd_data` into the staging register of channel `cmd_chan`. Channel 0 is the low slice of every bus.
  - No other channel's registers change.
- R3: Op 2 writes `cmd_data` into both the staging and the live register of channel `cmd_chan`.
- R4: Op 3 copies staging into live, in the same edge, for every channel whose bit in `cmd_mask` is 1. Bit i selects channel i. Channels whose bit is 0 keep their live value.
- R5: While `dac_hold` is low, each live register takes the value its staging register takes at the same edge. This includes a staging write made by that very command.
- R6: While `dac_hold` is high, a staging write does not change any live register.
- R7: The channel code for channel i is `code_out[12*i +: 12]`. It is registered, and it shows the register state one edge later:
  - it shows the staging register if `toggle_sel` was high at that edge;
  - it shows the live register if `toggle_sel` was low.
- R8: Op 4 stores `cmd_pdmode` as the pending power-down mode of every channel whose `cmd_mask` bit is 1. `sd_state` does not change.
- R9: Op 5 copies the pending mode into `sd_state[2*i +: 2]` for every masked channel i. The new state is visible right after that edge. No other command changes `sd_state`.
- R10: The force inputs load a fixed code into both registers of all channels at the next edge:
  - `force_clr` loads 0x000, `force_mid` loads 0x800 and `force_set` loads 0xFFF;
  - when several are high, clr wins over mid and mid wins over set;
  - a force overrides any command in the same cycle.
- R11: Op codes 0, 6 and 7 leave every register and power-down state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command op code |
| cmd_chan | input | 3 | Target channel for single-channel writes |
| cmd_data | input | 12 | Code for register writes |
| cmd_mask | input | 8 | Channel select mask for transfer and power-down ops |
| cmd_pdmode | input | 2 | Power-down mode value for op 4 |
| dac_hold | input | 1 | High latches live registers; low makes them transparent |
| toggle_sel | input | 1 | High shows staging codes; low shows live codes |
| force_clr | input | 1 | Force all codes to 0x000 |
| force_mid | input | 1 | Force all codes to 0x800 |
| force_set | input | 1 | Force all codes to 0xFFF |
| code_out | output | 96 | Eight channel codes, channel 0 in bits 11:0 |
| sd_state | output | 16 | Applied power-down state per channel, channel 0 in bits 1:0 |

## Verification
A force and a register-writing command can land in the same cycle. The bench provokes this by raising `force_set` in the same cycle as a two-register write carrying a different code. The bench then expects 0xFFF in every channel, including the addressed one, from both registers; the staging register is seen through `toggle_sel`.

A second collision is the release of `dac_hold` in a cycle where staging and live already differ. The bench expects the live registers to catch up at that edge. The checker module holds this for every cycle with `dac_hold` low.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_WR_STAGE = 3'd1,
    OP_WR_BOTH  = 3'd2,
    OP_XFER     = 3'd3,
    OP_PD_MODE  = 3'd4,
    OP_PD_APPLY = 3'd5
  } op_e;

  localparam int PD_W = 2;
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [CH_W-1:0]   cmd_chan,
  input  logic [NUM_CH-1:0] cmd_mask,
  output logic [NUM_CH-1:0] wr_stage,
  output logic [NUM_CH-1:0] wr_live,
  output logic [NUM_CH-1:0] xfer,
  output logic [NUM_CH-1:0] mode_we,
  output logic [NUM_CH-1:0] apply
);
  logic is_wr_stage, is_wr_both, is_xfer, is_mode, is_apply;

  always_comb begin
    is_wr_stage = 1'b0;
    is_wr_both  = 1'b0;
    is_xfer     = 1'b0;
    is_mode     = 1'b0;
    is_apply    = 1'b0;
    if (cmd_valid) begin
      case (cmd_op)
        OP_WR_STAGE: is_wr_stage = 1'b1;
        OP_WR_BOTH:  is_wr_both  = 1'b1;
        OP_XFER:     is_xfer     = 1'b1;
        OP_PD_MODE:  is_mode     = 1'b1;
        OP_PD_APPLY: is_apply    = 1'b1;
        default:     ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit         = (cmd_chan == CH_W'(g));
    assign wr_stage[g] = (is_wr_stage | is_wr_both) & hit;
    assign wr_live[g]  = is_wr_both & hit;
    assign xfer[g]     = is_xfer & cmd_mask[g];
    assign mode_we[g]  = is_mode & cmd_mask[g];
    assign apply[g]    = is_apply & cmd_mask[g];
  end
endmodule

// File: rtl/regbank_force.sv
module regbank_force #(
  parameter int CODE_W = 12
) (
  input  logic              clr,
  input  logic              mid,
  input  logic              set,
  output logic              force_en,
  output logic [CODE_W-1:0] force_code
);
  localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};

  always_comb begin
    force_en   = clr | mid | set;
    force_code = '0;
    if (clr)      force_code = '0;
    else if (mid) force_code = MID_CODE;
    else if (set) force_code = TOP_CODE;
  end
endmodule

// File: rtl/regbank_channel.sv
module regbank_channel #(
  parameter int CODE_W = 12,
  parameter int PD_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stage,
  input  logic              wr_live,
  input  logic              xfer,
  input  logic              mode_we,
  input  logic              apply,
  input  logic [CODE_W-1:0] wr_data,
  input  logic [PD_W-1:0]   mode_val,
  input  logic              hold,
  input  logic              toggle,
  input  logic              force_en,
  input  logic [CODE_W-1:0] force_code,
  output logic [CODE_W-1:0] stage_q,
  output logic [CODE_W-1:0] live_q,
  output logic [CODE_W-1:0] code_q,
  output logic [PD_W-1:0]   sd_q
);
  logic [CODE_W-1:0] stage_d, live_d;
  logic [PD_W-1:0]   mode_q;

  always_comb begin
    stage_d = stage_q;
    if (force_en)      stage_d = force_code;
    else if (wr_stage) stage_d = wr_data;

    live_d = live_q;
    if (force_en)     live_d = force_code;
    else if (!hold)   live_d = stage_d;
    else if (wr_live) live_d = wr_data;
    else if (xfer)    live_d = stage_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      live_q  <= '0;
      code_q  <= '0;
      mode_q  <= '0;
      sd_q    <= '0;
    end else begin
      stage_q <= stage_d;
      live_q  <= live_d;
      code_q  <= toggle ? stage_q : live_q;
      if (mode_we) mode_q <= mode_val;
      if (apply)   sd_q   <= mode_q;
    end
  end
endmodule

// File: rtl/octal_dac_regbank.sv
module octal_dac_regbank
  import regbank_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 12,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_valid,
  input  logic [2:0]               cmd_op,
  input  logic [CH_W-1:0]          cmd_chan,
  input  logic [CODE_W-1:0]        cmd_data,
  input  logic [NUM_CH-1:0]        cmd_mask,
  input  logic [PD_W-1:0]          cmd_pdmode,
  input  logic                     dac_hold,
  input  logic                     toggle_sel,
  input  logic                     force_clr,
  input  logic                     force_mid,
  input  logic                     force_set,
  output logic [NUM_CH*CODE_W-1:0] code_out,
  output logic [NUM_CH*PD_W-1:0]   sd_state
);
  localparam int FLAT_W = NUM_CH * CODE_W;

  logic [NUM_CH-1:0] wr_stage, wr_live, xfer, mode_we, apply;
  logic              force_en;
  logic [CODE_W-1:0] force_code;
  logic [FLAT_W-1:0] stage_flat, live_flat, code_flat;
  logic [NUM_CH*PD_W-1:0] sd_flat;

  regbank_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_decode (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_chan  (cmd_chan),
    .cmd_mask  (cmd_mask),
    .wr_stage  (wr_stage),
    .wr_live   (wr_live),
    .xfer      (xfer),
    .mode_we   (mode_we),
    .apply     (apply)
  );

  regbank_force #(.CODE_W(CODE_W)) u_force (
    .clr        (force_clr),
    .mid        (force_mid),
    .set        (force_set),
    .force_en   (force_en),
    .force_code (force_code)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    regbank_channel #(.CODE_W(CODE_W), .PD_W(PD_W)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .wr_stage   (wr_stage[g]),
      .wr_live    (wr_live[g]),
      .xfer       (xfer[g]),
      .mode_we    (mode_we[g]),
      .apply      (apply[g]),
      .wr_data    (cmd_data),
      .mode_val   (cmd_pdmode),
      .hold       (dac_hold),
      .toggle     (toggle_sel),
      .force_en   (force_en),
      .force_code (force_code),
      .stage_q    (stage_flat[g*CODE_W +: CODE_W]),
      .live_q     (live_flat[g*CODE_W +: CODE_W]),
      .code_q     (code_flat[g*CODE_W +: CODE_W]),
      .sd_q       (sd_flat[g*PD_W +: PD_W])
    );
  end

  assign code_out = code_flat;
  assign sd_state = sd_flat;
endmodule

// File: rtl/octal_dac_regbank_checker.sv
module octal_dac_regbank_checker #(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 12,
  parameter int PD_W   = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cmd_valid,
  input logic [2:0]               cmd_op,
  input logic                     dac_hold,
  input logic                     toggle_sel,
  input logic                     force_clr,
  input logic                     force_mid,
  input logic                     force_set,
  input logic [NUM_CH*CODE_W-1:0] stage_flat,
  input logic [NUM_CH*CODE_W-1:0] live_flat,
  input logic [NUM_CH*CODE_W-1:0] code_out,
  input logic [NUM_CH*PD_W-1:0]   sd_state
);
  logic force_any, live_cmd, apply_cmd;
  assign force_any = force_clr | force_mid | force_set;
  assign live_cmd  = cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd3);
  assign apply_cmd = cmd_valid && (cmd_op == 3'd5);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (code_out == '0 && sd_state == '0));

  assert_transparent_R5: assert property (@(posedge clk) disable iff (rst)
    !dac_hold |=> (live_flat == stage_flat));

  assert_hold_keeps_live_R6: assert property (@(posedge clk) disable iff (rst)
    (dac_hold && !force_any && !live_cmd) |=> $stable(live_flat));

  assert_sd_only_on_apply_R9: assert property (@(posedge clk) disable iff (rst)
    !apply_cmd |=> $stable(sd_state));

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
    force_clr |=> (stage_flat == '0 && live_flat == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_out
    assert_output_select_R7: assert property (@(posedge clk) disable iff (rst)
      !rst |=> code_out[g*CODE_W +: CODE_W] ==
        ($past(toggle_sel) ? $past(stage_flat[g*CODE_W +: CODE_W])
                           : $past(live_flat[g*CODE_W +: CODE_W])));
  end
endmodule

bind octal_dac_regbank octal_dac_regbank_checker #(
  .NUM_CH(NUM_CH), .CODE_W(CODE_W), .PD_W(regbank_pkg::PD_W)
) u_checker (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .dac_hold   (dac_hold),
  .toggle_sel (toggle_sel),
  .force_clr  (force_clr),
  .force_mid  (force_mid),
  .force_set  (force_set),
  .stage_flat (stage_flat),
  .live_flat  (live_flat),
  .code_out   (code_out),
  .sd_state   (sd_state)
);

// File: tb/octal_dac_regbank_test.sv
module octal_dac_regbank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [2:0]  cmd_chan = '0;
  logic [11:0] cmd_data = '0;
  logic [7:0]  cmd_mask = '0;
  logic [1:0]  cmd_pdmode = '0;
  logic        dac_hold = 1'b1;
  logic        toggle_sel = 1'b0;
  logic        force_clr = 1'b0, force_mid = 1'b0, force_set = 1'b0;
  logic [95:0] code_out;
  logic [15:0] sd_state;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [11:0] m_stage [8];
  logic [11:0] m_live  [8];
  logic [1:0]  m_mode  [8];
  logic [1:0]  m_sd    [8];

  always #4 clk = ~clk;

  octal_dac_regbank uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_chan(cmd_chan), .cmd_data(cmd_data), .cmd_mask(cmd_mask),
    .cmd_pdmode(cmd_pdmode), .dac_hold(dac_hold), .toggle_sel(toggle_sel),
    .force_clr(force_clr), .force_mid(force_mid), .force_set(force_set),
    .code_out(code_out), .sd_state(sd_state)
  );

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin
      m_stage[i] = '0; m_live[i] = '0; m_mode[i] = '0; m_sd[i] = '0;
    end
  endtask

  task automatic send(input logic [2:0] op, input int ch, input logic [11:0] d,
                      input logic [7:0] mk, input logic [1:0] pm);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_chan = ch[2:0];
    cmd_data = d; cmd_mask = mk; cmd_pdmode = pm;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0;
    case (op)
      3'd1: m_stage[ch] = d;
      3'd2: begin m_stage[ch] = d; m_live[ch] = d; end
      3'd3: for (int i = 0; i < 8; i++) if (mk[i]) m_live[i] = m_stage[i];
      3'd4: for (int i = 0; i < 8; i++) if (mk[i]) m_mode[i] = pm;
      3'd5: for (int i = 0; i < 8; i++) if (mk[i]) m_sd[i] = m_mode[i];
      default: ;
    endcase
    if (!dac_hold) for (int i = 0; i < 8; i++) m_live[i] = m_stage[i];
  endtask

  task automatic set_hold(input logic v);
    @(negedge clk);
    dac_hold = v;
    @(negedge clk);
    if (!v) for (int i = 0; i < 8; i++) m_live[i] = m_stage[i];
  endtask

  task automatic force_pulse(input logic c, input logic m, input logic s,
                             input logic [2:0] op, input int ch, input logic [11:0] d);
    logic [11:0] code;
    @(negedge clk);
    force_clr = c; force_mid = m; force_set = s;
    cmd_valid = 1'b1; cmd_op = op; cmd_chan = ch[2:0]; cmd_data = d; cmd_mask = 8'hFF;
    @(negedge clk);
    force_clr = 1'b0; force_mid = 1'b0; force_set = 1'b0;
    cmd_valid = 1'b0; cmd_op = '0;
    code = c ? 12'h000 : (m ? 12'h800 : 12'hFFF);
    for (int i = 0; i < 8; i++) begin m_stage[i] = code; m_live[i] = code; end
  endtask

  // Waits one edge so the registered codes reflect the model, then compares.
  task automatic check_all(input string tag);
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      logic [11:0] exp_code;
      exp_code = toggle_sel ? m_stage[i] : m_live[i];
      checks++;
      if (code_out[i*12 +: 12] !== exp_code) begin
        errors++;
        $display("FAIL %s ch%0d code actual=%h expected=%h", tag, i,
                 code_out[i*12 +: 12], exp_code);
      end
      checks++;
      if (sd_state[i*2 +: 2] !== m_sd[i]) begin
        errors++;
        $display("FAIL %s ch%0d sd actual=%b expected=%b", tag, i,
                 sd_state[i*2 +: 2], m_sd[i]);
      end
    end
  endtask

  task automatic t_reset_R1();
    check_all("R1");
  endtask

  task automatic t_stage_write_R2();
    send(3'd1, 2, 12'h123, 8'h00, 2'b00);
    check_all("R2/R6 live unchanged");
    toggle_sel = 1'b1;
    check_all("R2 staged visible");
    toggle_sel = 1'b0;
    check_all("R6");
  endtask

  task automatic t_both_write_R3();
    send(3'd2, 5, 12'hABC, 8'h00, 2'b00);
    check_all("R3");
    toggle_sel = 1'b1;
    check_all("R3 staging");
    toggle_sel = 1'b0;
  endtask

  task automatic t_xfer_R4();
    send(3'd1, 0, 12'h111, 8'h00, 2'b00);
    send(3'd1, 7, 12'h777, 8'h00, 2'b00);
    send(3'd1, 3, 12'h333, 8'h00, 2'b00);
    send(3'd3, 0, 12'h000, 8'h81, 2'b00);
    check_all("R4");
  endtask

  task automatic t_transparent_R5();
    set_hold(1'b0);
    check_all("R5 release catches up");
    send(3'd1, 1, 12'h456, 8'h00, 2'b00);
    check_all("R5 same-edge follow");
    set_hold(1'b1);
    send(3'd1, 1, 12'h999, 8'h00, 2'b00);
    check_all("R6 held after re-latch");
  endtask

  task automatic t_toggle_R7();
    for (int k = 0; k < 4; k++) begin
      toggle_sel = k[0];
      check_all("R7");
    end
    toggle_sel = 1'b0;
  endtask

  task automatic t_powerdown_R8_R9();
    send(3'd4, 0, 12'h000, 8'h0F, 2'b01);
    check_all("R8");
    send(3'd5, 0, 12'h000, 8'h03, 2'b00);
    check_all("R9 apply subset");
    send(3'd4, 0, 12'h000, 8'h80, 2'b11);
    send(3'd5, 0, 12'h000, 8'hFF, 2'b00);
    check_all("R9 apply all");
    send(3'd4, 0, 12'h000, 8'h01, 2'b00);
    send(3'd5, 0, 12'h000, 8'h01, 2'b00);
    check_all("R9 wake");
  endtask

  task automatic t_force_R10();
    force_pulse(1'b0, 1'b1, 1'b0, 3'd0, 0, 12'h000);
    check_all("R10 mid");
    force_pulse(1'b1, 1'b0, 1'b1, 3'd0, 0, 12'h000);
    check_all("R10 clr beats set");
    force_pulse(1'b0, 1'b1, 1'b1, 3'd0, 0, 12'h000);
    check_all("R10 mid beats set");
    force_pulse(1'b0, 1'b0, 1'b1, 3'd2, 4, 12'h0A5);
    check_all("R10 set beats write");
    toggle_sel = 1'b1;
    check_all("R10 staging forced");
    toggle_sel = 1'b0;
  endtask

  task automatic t_ignored_R11();
    send(3'd1, 6, 12'h246, 8'h00, 2'b00);
    for (int op = 6; op < 8; op++) begin
      send(op[2:0], 6, 12'h5A5, 8'hFF, 2'b11);
    end
    send(3'd0, 6, 12'h5A5, 8'hFF, 2'b11);
    check_all("R11 live");
    toggle_sel = 1'b1;
    check_all("R11 staging");
    toggle_sel = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_R1();
    t_stage_write_R2();
    t_both_write_R3();
    t_xfer_R4();
    t_transparent_R5();
    t_toggle_R7();
    t_powerdown_R8_R9();
    t_force_R10();
    t_ignored_R11();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule